// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This peripheral block shares one 16-bit value register between three functions, chosen by a 4-bit mode code held in a control register. In capture mode it watches an input pin and copies the value of an external 16-bit free-running timer into the value register when a chosen edge arrives, optionally only on every 4th or 16th rising edge. In compare mode it checks the same register against that timer. On a match it either drives the output pin to a fixed level, or raises an interrupt flag only, or also emits a one-cycle special event that the surrounding system uses to reset the 16-bit timer.

In PWM mode the block produces a pulse train against an external 8-bit period timer and its 2-bit fine sub-count. The cycle length comes from a period input. A 10-bit duty value is assembled from the low byte of the value register (upper 8 bits) and two control bits (lower 2 bits). The duty value is taken into a shadow copy only at a period boundary, so software can rewrite it at any time without a glitch. The timers, their prescaler and any converter hardware sit outside the block. The conversion-start output is only active on instances built with the conversion parameter set.

Top module: `ccp_unit`

## Requirements
- R1: Out of reset, pin_o, flag_o, event_o and adc_start_o are low and val_o is zero.
- R2: A write with wr_sel_i 0 loads val_o[7:0] and wr_sel_i 1 loads val_o[15:8]. wr_sel_i 2 loads the control register: bits 3:0 are the mode code and bits 5:4 are the duty LSBs. wr_sel_i 3 changes nothing. A capture in the same cycle wins over a value write.
- R3: Mode codes 0000 to 0011 disable the block. Within one cycle flag_o clears, pin_o goes low and the capture edge count and PWM state clear. No match or edge sets the flag in these modes.
- R4: Mode 0100 captures on every falling edge of pin_i and 0101 captures on every rising edge. A capture copies tmr_i into val_o and sets flag_o. pin_i passes through a two-stage synchronizer, and the capture completes on the third clock edge after the pin changes. Edges of the other polarity are ignored.
- R5: Mode 0110 captures on every 4th rising edge and 0111 on every 16th. The edge count restarts from zero whenever the mode code changes.
- R6: When mode 1000 is entered, pin_o is driven low, and when 1001 is entered it is driven high. When tmr_i becomes equal to val_o, 1000 drives pin_o high and 1001 drives it low, and both set flag_o. Each result shows on the clock edge that samples the match.
- R7: Modes 1010 and 1011 set flag_o on a match and leave pin_o unchanged. Mode 1011 also pulses event_o high for exactly one cycle. adc_start_o pulses with it when CONV_EN is 1.
- R8: flag_o stays set until flag_clr_i is sampled high with no new event in the same cycle, or until the block is disabled.
- R9: Any mode 11xx selects PWM. The count is {ptmr_i, fine_i}, and the period ends at count {period_i, 2'b11}. The duty value D = {val_o[7:0], ctrl[5:4]} is latched at that last count. In every following cycle that presents count c, pin_o equals (c < D).
- R10: With a latched D of 0, pin_o stays low for the whole period. With D at or above (period_i+1)*4, pin_o stays high for the whole period.
- R11: A duty write in the middle of a period leaves the current period unchanged and takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 low byte, 1 high byte, 2 control, 3 none |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| pin_i | input | 1 | Capture input pin, asynchronous |
| tmr_i | input | 16 | 16-bit free-running timer value |
| ptmr_i | input | 8 | PWM period timer |
| fine_i | input | 2 | PWM fine sub-count, low bits of the 10-bit count |
| period_i | input | 8 | PWM period limit |
| pin_o | output | 1 | Output pin |
| flag_o | output | 1 | Interrupt flag |
| event_o | output | 1 | Special-event pulse (timer reset request) |
| adc_start_o | output | 1 | Conversion-start pulse |
| val_o | output | 16 | Capture/compare value register |

## Verification
A stuck or mis-cleared edge counter shows as a capture on the wrong edge of a counted burst, visible on val_o and flag_o within three cycles of that edge. A wrong shadow duty or a wrong period-end decode moves the falling edge of pin_o in the first PWM period after the fault, so the bench checks pin_o on every count across several periods. A bad compare latch or event register shows on pin_o or event_o on the cycle that follows the match, and a pulse that lasts too long shows one cycle after that.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int MODE_W = 4;

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [1:0] {K_OFF, K_CAP, K_CMP, K_PWM} kind_e;

  function automatic kind_e kind_of(input logic [MODE_W-1:0] m);
    if (m[3:2] == 2'b11) return K_PWM;
    if (m[3])            return K_CMP;
    if (m[2])            return K_CAP;
    return K_OFF;
  endfunction
endpackage

// File: rtl/ccp_regs.sv
module ccp_regs #(
  parameter int REG_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [1:0]                   wr_sel_i,
  input  logic [REG_W-1:0]             wr_data_i,
  input  logic                         cap_i,
  input  logic [2*REG_W-1:0]           cap_val_i,
  output logic [2*REG_W-1:0]           val_o,
  output logic [ccp_pkg::MODE_W-1:0]   mode_o,
  output logic [FINE_W-1:0]            fine_o
);
  import ccp_pkg::*;
  localparam int CTRL_W = MODE_W + FINE_W;

  logic [REG_W-1:0]  lo_q, hi_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (cap_i) begin
        {hi_q, lo_q} <= cap_val_i;
      end else if (wr_en_i) begin
        case (wr_sel_i)
          SEL_LO:  lo_q <= wr_data_i;
          SEL_HI:  hi_q <= wr_data_i;
          default: ;
        endcase
      end
      if (wr_en_i && wr_sel_i == SEL_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  assign val_o  = {hi_q, lo_q};
  assign mode_o = ctrl_q[MODE_W-1:0];
  assign fine_o = ctrl_q[CTRL_W-1:MODE_W];
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int PS_MID  = 4,
  parameter int PS_SLOW = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       active_i,
  input  logic [1:0] sub_i,
  input  logic       chg_i,
  output logic       cap_o
);
  localparam int CNT_W = $clog2(PS_SLOW + 1);
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(PS_MID - 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(PS_SLOW - 1);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic             rise, fall, edg;

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];
  assign edg  = (sub_i == 2'b00) ? fall : rise;

  always_comb begin
    case (sub_i)
      2'b10:   lim = LIM_MID;
      2'b11:   lim = LIM_SLOW;
      default: lim = '0;
    endcase
  end

  assign cap_o = active_i && !chg_i && edg && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_i};
      if (!active_i || chg_i) cnt_q <= '0;
      else if (edg)           cnt_q <= cap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
  parameter int TMR_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ccp_pkg::MODE_W-1:0] mode_i,
  input  logic                       chg_i,
  input  logic                       off_i,
  input  logic [TMR_W-1:0]           tmr_i,
  input  logic [TMR_W-1:0]           val_i,
  output logic                       out_o,
  output logic                       hit_o,
  output logic                       evt_o
);
  logic is_cmp, match, match_q, out_q, evt_q;

  assign is_cmp = (mode_i[3:2] == 2'b10);
  assign match  = (tmr_i == val_i);
  // act only on the cycle the timer arrives at the value
  assign hit_o  = is_cmp && !chg_i && match && !match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      out_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      match_q <= match;
      evt_q   <= hit_o && (mode_i[1:0] == 2'b11);
      if (off_i)                             out_q <= 1'b0;
      else if (chg_i && is_cmp && !mode_i[1]) out_q <= mode_i[0];
      else if (hit_o && !mode_i[1])          out_q <= ~mode_i[0];
    end
  end

  assign out_o = out_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int REG_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    active_i,
  input  logic [REG_W-1:0]        tmr_i,
  input  logic [FINE_W-1:0]       fine_i,
  input  logic [REG_W-1:0]        period_i,
  input  logic [REG_W+FINE_W-1:0] duty_i,
  output logic                    out_o
);
  localparam int DUTY_W = REG_W + FINE_W;

  logic [DUTY_W-1:0] cnt, last, shadow_q;
  logic              end_t, fall_t, out_q;

  assign cnt    = {tmr_i, fine_i};
  assign last   = {period_i, {FINE_W{1'b1}}};
  assign end_t  = (cnt == last);
  // drop one count early: the registered pin then turns low exactly at count D
  assign fall_t = (shadow_q != '0) && (cnt == shadow_q - DUTY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      out_q    <= 1'b0;
    end else if (!active_i) begin
      shadow_q <= '0;
      out_q    <= 1'b0;
    end else if (end_t) begin
      shadow_q <= duty_i;
      out_q    <= (duty_i != '0);
    end else if (fall_t) begin
      out_q    <= 1'b0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit #(
  parameter int REG_W   = 8,
  parameter int FINE_W  = 2,
  parameter int PS_MID  = 4,
  parameter int PS_SLOW = 16,
  parameter bit CONV_EN = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               flag_clr_i,
  input  logic               pin_i,
  input  logic [2*REG_W-1:0] tmr_i,
  input  logic [REG_W-1:0]   ptmr_i,
  input  logic [FINE_W-1:0]  fine_i,
  input  logic [REG_W-1:0]   period_i,
  output logic               pin_o,
  output logic               flag_o,
  output logic               event_o,
  output logic               adc_start_o,
  output logic [2*REG_W-1:0] val_o
);
  import ccp_pkg::*;
  localparam int TMR_W = 2 * REG_W;

  logic [MODE_W-1:0] mode, mode_q;
  logic [FINE_W-1:0] duty_lsb;
  logic [TMR_W-1:0]  val;
  logic              mode_chg, cap_stb, hit, cmp_out, pwm_out, evt, flag_q;
  kind_e             kind;

  assign kind     = kind_of(mode);
  assign mode_chg = (mode != mode_q);

  ccp_regs #(.REG_W(REG_W), .FINE_W(FINE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .cap_i(cap_stb), .cap_val_i(tmr_i),
    .val_o(val), .mode_o(mode), .fine_o(duty_lsb)
  );

  ccp_capture #(.PS_MID(PS_MID), .PS_SLOW(PS_SLOW)) u_cap (
    .clk_i, .rst_ni, .pin_i,
    .active_i(kind == K_CAP), .sub_i(mode[1:0]), .chg_i(mode_chg),
    .cap_o(cap_stb)
  );

  ccp_compare #(.TMR_W(TMR_W)) u_cmp (
    .clk_i, .rst_ni, .mode_i(mode), .chg_i(mode_chg), .off_i(kind == K_OFF),
    .tmr_i, .val_i(val), .out_o(cmp_out), .hit_o(hit), .evt_o(evt)
  );

  ccp_pwm #(.REG_W(REG_W), .FINE_W(FINE_W)) u_pwm (
    .clk_i, .rst_ni, .active_i(kind == K_PWM),
    .tmr_i(ptmr_i), .fine_i, .period_i,
    .duty_i({val[REG_W-1:0], duty_lsb}), .out_o(pwm_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode;
      if (kind == K_OFF)       flag_q <= 1'b0;
      else if (cap_stb || hit) flag_q <= 1'b1;
      else if (flag_clr_i)     flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (kind)
      K_CMP:   pin_o = cmp_out;
      K_PWM:   pin_o = pwm_out;
      default: pin_o = 1'b0;
    endcase
  end

  generate
    if (CONV_EN) begin : g_conv
      assign adc_start_o = evt;
    end else begin : g_noconv
      assign adc_start_o = 1'b0;
    end
  endgenerate

  assign flag_o  = flag_q;
  assign event_o = evt;
  assign val_o   = val;
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pin_o,
  input logic             flag_o,
  input logic             event_o,
  input logic             adc_start_o,
  input logic [TMR_W-1:0] val_o,
  input logic             flag_clr_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [3:0]       mode_i,
  input logic             cap_i
);
  logic mode_off, quiet;
  assign mode_off = (mode_i[3:2] == 2'b00);
  assign quiet    = (mode_i == 4'hA) || (mode_i == 4'hB);

  // R3
  off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_off |=> (!flag_o && !pin_o));

  // R7
  event_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  // R7
  event_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(mode_i == 4'hB));

  // R7
  conv_with_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> event_o);

  // R7
  quiet_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && $past(quiet)) |-> $stable(pin_o));

  // R8
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i || mode_off));

  // R2
  val_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(val_o) |-> $past(cap_i || (wr_en_i && wr_sel_i[1] == 1'b0)));
endmodule

bind ccp_unit ccp_unit_chk #(.TMR_W(2 * REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_o(pin_o), .flag_o(flag_o),
  .event_o(event_o), .adc_start_o(adc_start_o), .val_o(val_o),
  .flag_clr_i(flag_clr_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .mode_i(mode), .cap_i(cap_stb)
);

// File: tb/tb_ccp_unit.sv
`timescale 1ns/100ps
module tb_ccp_unit;
  localparam int S_PIN = 0, S_FLAG = 1, S_EVT = 2, S_ADC = 3, S_VAL = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0, flag_clr = 1'b0, pin = 1'b0;
  logic [1:0]  wr_sel = 2'd3, fine = 2'd0;
  logic [7:0]  wr_data = '0, ptmr = '0, period = '0;
  logic [15:0] tmr = '0;
  logic        pin_o, flag_o, event_o, adc_o;
  logic [15:0] val_o;

  always #2.5 clk = ~clk;

  ccp_unit #(.CONV_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .flag_clr_i(flag_clr), .pin_i(pin), .tmr_i(tmr),
    .ptmr_i(ptmr), .fine_i(fine), .period_i(period), .pin_o(pin_o),
    .flag_o(flag_o), .event_o(event_o), .adc_start_o(adc_o), .val_o(val_o)
  );

  typedef struct {string req; int sel; int exp;} item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // monitor: compares pushed expectations 2 ns after each edge
  initial forever begin
    @(posedge clk); #2;
    while (exp_q.size() > 0) begin
      item_t it;
      int obs;
      it = exp_q.pop_front();
      case (it.sel)
        S_PIN:   obs = int'(pin_o);
        S_FLAG:  obs = int'(flag_o);
        S_EVT:   obs = int'(event_o);
        S_ADC:   obs = int'(adc_o);
        default: obs = int'(val_o);
      endcase
      checks++;
      if (obs != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, obs, it.exp);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // driver helpers: push one expectation for the cycle after the next edge
  task automatic expect_next(input string req, input int sel, input int exp);
    @(posedge clk); #1;
    exp_q.push_back('{req, sel, exp});
  endtask

  task automatic expect_same(input string req, input int sel, input int exp);
    exp_q.push_back('{req, sel, exp});
  endtask

  task automatic write_reg(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pin_edge(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_tmr(input int v);
    @(negedge clk); tmr = 16'(v);
  endtask

  // PWM model state
  int duty_m = 0, shadow_m = 0, cnt_m = 0, n_m = 20;
  bit armed = 1'b0;

  task automatic pwm_tick(input string req, input bit chk, input int wsel, input int wdat);
    int nxt;
    @(negedge clk);
    ptmr = 8'(cnt_m / 4); fine = 2'(cnt_m % 4);
    wr_en = (wsel != 3); wr_sel = 2'(wsel); wr_data = 8'(wdat);
    if (cnt_m == n_m - 1) begin shadow_m = duty_m; armed = 1'b1; end
    if (wsel == 0) duty_m = (wdat * 4) + (duty_m % 4);
    if (wsel == 2) duty_m = (duty_m / 4) * 4 + ((wdat >> 4) & 3);
    nxt = (cnt_m == n_m - 1) ? 0 : cnt_m + 1;
    @(posedge clk); #1;
    if (chk && armed) exp_q.push_back('{req, S_PIN, int'(nxt < shadow_m)});
    cnt_m = nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    expect_next("R1", S_PIN, 0);
    expect_same("R1", S_FLAG, 0);
    expect_same("R1", S_EVT, 0);
    expect_same("R1", S_ADC, 0);
    expect_same("R1", S_VAL, 0);

    // R2 register writes
    write_reg(0, 8'hA5);
    write_reg(1, 8'h3C);
    expect_next("R2 byte writes", S_VAL, 16'h3CA5);
    write_reg(3, 8'hFF);
    expect_next("R2 no-target write", S_VAL, 16'h3CA5);

    // R4 rising-edge capture
    write_reg(2, 8'h05);
    set_tmr(16'h1234);
    pin_edge(1'b1);
    expect_next("R4 rising capture", S_VAL, 16'h1234);
    expect_same("R4 flag on capture", S_FLAG, 1);
    clear_flag();
    expect_next("R8 flag clear", S_FLAG, 0);
    set_tmr(16'h5555);
    pin_edge(1'b0);
    expect_next("R4 falling ignored", S_VAL, 16'h1234);
    expect_same("R4 falling ignored flag", S_FLAG, 0);

    // R4 falling-edge capture
    write_reg(2, 8'h04);
    set_tmr(16'h4444);
    pin_edge(1'b1);
    expect_next("R4 rising ignored in falling mode", S_VAL, 16'h1234);
    pin_edge(1'b0);
    expect_next("R4 falling capture", S_VAL, 16'h4444);

    // R5 every 4th rising edge
    write_reg(2, 8'h06);
    for (int i = 1; i <= 4; i++) begin
      set_tmr(i * 16'h0111);
      pin_edge(1'b1);
      pin_edge(1'b0);
      if (i == 3) expect_next("R5 no capture before 4th", S_VAL, 16'h4444);
    end
    expect_next("R5 capture on 4th", S_VAL, 16'h0444);

    // R5 every 16th rising edge
    write_reg(2, 8'h07);
    for (int i = 1; i <= 16; i++) begin
      set_tmr(i * 16'h0101);
      pin_edge(1'b1);
      pin_edge(1'b0);
      if (i == 15) expect_next("R5 no capture before 16th", S_VAL, 16'h0444);
    end
    expect_next("R5 capture on 16th", S_VAL, 16'h1010);

    // R5 count restarts on mode change
    write_reg(2, 8'h06);
    for (int i = 1; i <= 2; i++) begin
      set_tmr(16'h2000 + i);
      pin_edge(1'b1);
      pin_edge(1'b0);
    end
    write_reg(2, 8'h07);
    write_reg(2, 8'h06);
    for (int i = 1; i <= 4; i++) begin
      set_tmr(16'h3000 + i);
      pin_edge(1'b1);
      pin_edge(1'b0);
      if (i == 3) expect_next("R5 count cleared by mode change", S_VAL, 16'h1010);
    end
    expect_next("R5 capture after restart", S_VAL, 16'h3004);

    // R3 disable clears flag
    write_reg(2, 8'h00);
    expect_next("R3 off clears flag", S_FLAG, 0);

    // R6 compare set-on-match
    set_tmr(0);
    write_reg(0, 8'h00);
    write_reg(1, 8'h01);
    write_reg(2, 8'h08);
    expect_next("R6 entry low", S_PIN, 0);
    set_tmr(16'h00FF);
    expect_next("R6 no match", S_PIN, 0);
    set_tmr(16'h0100);
    expect_next("R6 set on match", S_PIN, 1);
    expect_same("R6 flag on match", S_FLAG, 1);

    // R6 compare clear-on-match
    set_tmr(0);
    write_reg(2, 8'h00);
    expect_next("R3 off pin low", S_PIN, 0);
    write_reg(2, 8'h09);
    expect_next("R6 entry high", S_PIN, 1);
    expect_same("R6 no flag yet", S_FLAG, 0);
    set_tmr(16'h0100);
    expect_next("R6 clear on match", S_PIN, 0);
    expect_same("R6 flag on match", S_FLAG, 1);

    // R7 flag-only mode keeps pin
    set_tmr(0);
    write_reg(2, 8'h00);
    write_reg(2, 8'h09);
    write_reg(2, 8'h0A);
    expect_next("R7 entry keeps pin", S_PIN, 1);
    set_tmr(16'h0100);
    expect_next("R7 flag-only pin kept", S_PIN, 1);
    expect_same("R7 flag-only flag", S_FLAG, 1);
    expect_same("R7 no event in 1010", S_EVT, 0);

    // R7 special event
    set_tmr(0);
    clear_flag();
    write_reg(2, 8'h0B);
    expect_next("R8 flag cleared", S_FLAG, 0);
    set_tmr(16'h0100);
    expect_next("R7 event pulse", S_EVT, 1);
    expect_same("R7 conversion pulse", S_ADC, 1);
    expect_same("R7 event pin kept", S_PIN, 1);
    expect_next("R7 event one cycle", S_EVT, 0);
    expect_same("R7 conversion one cycle", S_ADC, 0);
    repeat (3) @(negedge clk);
    expect_next("R8 flag sticky", S_FLAG, 1);

    // R3 reserved code behaves as disabled
    set_tmr(0);
    write_reg(2, 8'h03);
    expect_next("R3 reserved pin low", S_PIN, 0);
    expect_same("R3 reserved flag low", S_FLAG, 0);
    set_tmr(16'h0100);
    expect_next("R3 reserved no match flag", S_FLAG, 0);

    // R9 PWM: period 4 -> 20 counts, duty 10
    @(negedge clk); ptmr = 0; fine = 0; period = 8'd4;
    write_reg(0, 8'h02);
    write_reg(2, 8'h2C);
    duty_m = 10; cnt_m = 0; n_m = 20; armed = 1'b0;
    for (int i = 0; i < 20; i++) pwm_tick("R9", 1'b0, 3, 0);
    for (int i = 0; i < 40; i++) pwm_tick("R9 duty 10", 1'b1, 3, 0);

    // R11 mid-period duty change (10 -> 2)
    for (int i = 0; i < 5; i++) pwm_tick("R11", 1'b1, 3, 0);
    pwm_tick("R11 write mid period", 1'b1, 0, 0);
    for (int i = 0; i < 14; i++) pwm_tick("R11 old duty kept", 1'b1, 3, 0);
    for (int i = 0; i < 20; i++) pwm_tick("R11 new duty", 1'b1, 3, 0);

    // R10 duty 0 via mode 1111 with zero LSBs
    pwm_tick("R10", 1'b1, 2, 8'h0F);
    for (int i = 0; i < 40; i++) pwm_tick("R10 duty zero", 1'b1, 3, 0);

    // R10 duty 20 (full period)
    pwm_tick("R10", 1'b1, 0, 5);
    for (int i = 0; i < 40; i++) pwm_tick("R10 duty full", 1'b1, 3, 0);

    // R3 disable from PWM
    write_reg(2, 8'h00);
    expect_next("R3 off from PWM", S_PIN, 0);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule